// File: doc/BRIEF.md
# Test-Configurable Permutation Logic Cell

This block models one configurable logic element made of a K-input lookup table, an input multiplexer with an alternate data input, and a pipeline flip-flop. It is wrapped so that it takes a K-bit word in and gives a K-bit word out. One output position, chosen by the configuration, carries the table result. Every other input bit is wired straight across to the output bit with the same index. When the table is loaded so that its result equals the input bit in the chosen position, or the inverse of that bit, the cell maps its input word one-to-one onto its output word. Identical cells can then be chained into a linear array: an exhaustive counter sequence applied at one end stays exhaustive along the chain, and any corruption reaches the far end.

Configuration is loaded serially through a shift port while an enable is held high. The word holds the table bits, the output position, a register-select bit and an alternate-input select bit. A build-time option adds fault-injection inputs. They can force a table bit stuck at 0 or 1, model a decoder that reads two table cells at once (wired-OR), and force the multiplexer output stuck at 0 or 1 or wired-OR of both multiplexer inputs. With the option off, these inputs are ignored.

Top module: `lut_test_cell`

## Requirements
- R1: A synchronous active-high `rst` clears the pipeline register. In registered mode `dout` reads 0 in the cycle after any clock edge that sampled `rst` high.
- R2: On each clock edge with `cfg_en` high, the configuration shifts left by one and `cfg_bit` enters bit 0. With `cfg_en` low, the configuration holds whatever `cfg_bit` does.
- R3: Configuration layout, for a table depth D = 2^K and a position field of S bits: bits D-1..0 hold the table, with bit a being the result for address a; bits D+S-1..D hold the output position; bit D+S is the register select; bit D+S+1 (the MSB) is the alternate select. The word is shifted in MSB first.
- R4: In combinational mode (register select 0), `dout[p]` equals the multiplexer result in the same cycle, where p is the output position. Every other `dout[j]` equals `din[j]`. The table is addressed by the whole of `din`.
- R5: An output position of K or more places no table result, and `dout` equals `din`.
- R6: With position i and table bit a equal to bit i of a, `dout` equals `din` for every input. With that table inverted, `dout` equals `din` with bit i flipped.
- R7: With alternate select 1, the multiplexer passes `alt_in` and the table contents have no effect on `dout`.
- R8: In registered mode (register select 1), the whole output word is taken from the previous clock edge, with exactly one cycle of latency. A change of `din` between edges does not reach `dout`.
- R9: With fault injection built in, `flt_mem_mode` 1 or 2 forces table cell `flt_mem_idx` to 0 or 1. Mode 3 ORs that cell into every table read. Mode 0 is fault-free.
- R10: With fault injection built in, `flt_mux_mode` 1 or 2 forces the multiplexer output to 0 or 1. Mode 3 gives the OR of the table result and `alt_in`. Mode 0 is fault-free.
- R11: With fault injection left out of the build, the fault inputs have no effect on `dout`.
- R12: Reset does not alter the configuration. A shift requested in the same cycle as reset still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline register |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| din | input | K | Input word; also the table address |
| alt_in | input | 1 | Alternate multiplexer data input |
| flt_mem_mode | input | 2 | Table-cell fault mode (0 none, 1 stuck-0, 2 stuck-1, 3 wired-OR read) |
| flt_mem_idx | input | K | Table cell that the fault affects |
| flt_mux_mode | input | 2 | Multiplexer fault mode (0 none, 1 stuck-0, 2 stuck-1, 3 both inputs ORed) |
| dout | output | K | Output word |

## Verification
Reset and configuration loading can land on the same clock edge. Reset clears only the data pipeline, while the shift register keeps moving. The bench holds a registered configuration with a nonzero captured word. It then raises `rst` and `cfg_en` together, with a 1 on `cfg_bit`. That single shift clears the register-select bit and sets the alternate select. The cell is then swept over every input and alternate value, and the results must match a model of the shifted word, which shows the shift took effect even though reset was high. The reset itself is judged separately: with a registered configuration, `dout` must read zero on each edge that sampled `rst` high.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
   typedef enum logic [1:0] {MEM_OK = 2'd0, MEM_SA0 = 2'd1, MEM_SA1 = 2'd2, MEM_WOR = 2'd3} mem_flt_e;
   typedef enum logic [1:0] {MUX_OK = 2'd0, MUX_SA0 = 2'd1, MUX_SA1 = 2'd2, MUX_WOR = 2'd3} mux_flt_e;

   function automatic int pos_width(input int k);
      return (k <= 2) ? 1 : $clog2(k);
   endfunction

   function automatic int cfg_length(input int k);
      return (1 << k) + pos_width(k) + 2;
   endfunction
endpackage

// File: rtl/lutcell_cfg.sv
module lutcell_cfg #(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         cfg_en,
   input  logic         cfg_bit,
   output logic [N-1:0] cfg_q
);
   logic [N-1:0] chain;

   always_ff @(posedge clk) begin
      if (cfg_en) chain <= {chain[N-2:0], cfg_bit};
   end

   assign cfg_q = chain;
endmodule

// File: rtl/lutcell_lut.sv
module lutcell_lut import lutcell_pkg::*; #(
   parameter int K        = 3,
   parameter bit FAULT_EN = 1'b0,
   localparam int DEPTH   = 1 << K
) (
   input  logic [DEPTH-1:0] table_bits,
   input  logic [K-1:0]     addr,
   input  logic [1:0]       flt_mode,
   input  logic [K-1:0]     flt_idx,
   output logic             rd_bit
);
   generate
      if (FAULT_EN) begin : g_flt
         logic [DEPTH-1:0] cells;
         mem_flt_e         mode;
         assign mode = mem_flt_e'(flt_mode);
         always_comb begin
            cells = table_bits;
            if (mode == MEM_SA0) cells[flt_idx] = 1'b0;
            if (mode == MEM_SA1) cells[flt_idx] = 1'b1;
            rd_bit = cells[addr];
            if (mode == MEM_WOR) rd_bit = table_bits[addr] | table_bits[flt_idx];
         end
      end else begin : g_clean
         logic unused_flt;
         assign unused_flt = ^{flt_mode, flt_idx};
         assign rd_bit     = table_bits[addr];
      end
   endgenerate
endmodule

// File: rtl/lutcell_out.sv
module lutcell_out import lutcell_pkg::*; #(
   parameter int K        = 3,
   parameter bit FAULT_EN = 1'b0,
   localparam int SW      = pos_width(K)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [K-1:0]  din,
   input  logic          lut_bit,
   input  logic          alt_in,
   input  logic          alt_sel,
   input  logic          reg_sel,
   input  logic [SW-1:0] pos,
   input  logic [1:0]    flt_mode,
   output logic [K-1:0]  dout
);
   logic         mux_ok;
   logic         mux_y;
   logic [K-1:0] word;
   logic [K-1:0] pipe_q;

   assign mux_ok = alt_sel ? alt_in : lut_bit;

   generate
      if (FAULT_EN) begin : g_flt
         mux_flt_e mode;
         assign mode = mux_flt_e'(flt_mode);
         always_comb begin
            unique case (mode)
               MUX_SA0: mux_y = 1'b0;
               MUX_SA1: mux_y = 1'b1;
               MUX_WOR: mux_y = lut_bit | alt_in;
               default: mux_y = mux_ok;
            endcase
         end
      end else begin : g_clean
         logic unused_flt;
         assign unused_flt = ^flt_mode;
         assign mux_y      = mux_ok;
      end
   endgenerate

   for (genvar j = 0; j < K; j++) begin : g_bit
      assign word[j] = (pos == SW'(j)) ? mux_y : din[j];
   end

   always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= word;
   end

   assign dout = reg_sel ? pipe_q : word;
endmodule

// File: rtl/lut_test_cell.sv
module lut_test_cell import lutcell_pkg::*; #(
   parameter int K        = 3,
   parameter bit FAULT_EN = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cfg_en,
   input  logic         cfg_bit,
   input  logic [K-1:0] din,
   input  logic         alt_in,
   input  logic [1:0]   flt_mem_mode,
   input  logic [K-1:0] flt_mem_idx,
   input  logic [1:0]   flt_mux_mode,
   output logic [K-1:0] dout
);
   localparam int DEPTH   = 1 << K;
   localparam int SW      = pos_width(K);
   localparam int CFG_N   = cfg_length(K);
   localparam int POS_LO  = DEPTH;
   localparam int REG_BIT = DEPTH + SW;
   localparam int ALT_BIT = DEPTH + SW + 1;

   if (K < 2 || K > 8) begin : g_bad_k
      $error("lut_test_cell: K must lie in 2..8");
   end

   logic [CFG_N-1:0] cfg_q;
   logic [DEPTH-1:0] table_bits;
   logic [SW-1:0]    pos;
   logic             reg_sel;
   logic             alt_sel;
   logic             lut_bit;

   assign table_bits = cfg_q[DEPTH-1:0];
   assign pos        = cfg_q[REG_BIT-1:POS_LO];
   assign reg_sel    = cfg_q[REG_BIT];
   assign alt_sel    = cfg_q[ALT_BIT];

   lutcell_cfg #(.N(CFG_N)) u_cfg (
      .clk(clk), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_q(cfg_q)
   );

   lutcell_lut #(.K(K), .FAULT_EN(FAULT_EN)) u_lut (
      .table_bits(table_bits), .addr(din), .flt_mode(flt_mem_mode),
      .flt_idx(flt_mem_idx), .rd_bit(lut_bit)
   );

   lutcell_out #(.K(K), .FAULT_EN(FAULT_EN)) u_out (
      .clk(clk), .rst(rst), .din(din), .lut_bit(lut_bit), .alt_in(alt_in),
      .alt_sel(alt_sel), .reg_sel(reg_sel), .pos(pos), .flt_mode(flt_mux_mode),
      .dout(dout)
   );
endmodule

// File: rtl/lut_test_cell_chk.sv
module lut_test_cell_chk #(
   parameter int K  = 3,
   parameter int N  = 12,
   parameter int SW = 2
) (
   input logic          clk,
   input logic          rst,
   input logic          cfg_en,
   input logic          cfg_bit,
   input logic [K-1:0]  din,
   input logic [K-1:0]  dout,
   input logic [N-1:0]  cfg_q,
   input logic          reg_sel,
   input logic [SW-1:0] pos
);
   logic         armed = 1'b0;
   logic [K-1:0] hit_mask;

   always_ff @(posedge clk) if (rst) armed <= 1'b1;

   assign hit_mask = K'(1) << pos;

   assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
      (armed && cfg_en) |=> (cfg_q[0] == $past(cfg_bit) && cfg_q[N-1:1] == $past(cfg_q[N-2:0])));

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (armed && !cfg_en) |=> $stable(cfg_q));

   assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
      (armed && !reg_sel) |-> (((dout ^ din) & ~hit_mask) == '0));

   assert_pipe_latency_R8: assert property (@(posedge clk) disable iff (rst)
      (armed && reg_sel && $past(reg_sel) && !$past(cfg_en) && !$past(rst))
      |-> (((dout ^ $past(din)) & ~hit_mask) == '0));

   assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
      (armed && reg_sel && $past(rst) && !$past(cfg_en)) |-> (dout == '0));
endmodule

bind lut_test_cell lut_test_cell_chk #(.K(K), .N(CFG_N), .SW(SW)) u_chk (
   .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .din(din),
   .dout(dout), .cfg_q(cfg_q), .reg_sel(reg_sel), .pos(pos)
);

// File: tb/lut_test_cell_bench.sv
module lut_test_cell_bench;
   localparam int K = 3;
   localparam int N = 12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_en = 1'b0;
   logic       cfg_bit = 1'b0;
   logic [2:0] din = '0;
   logic       alt_in = 1'b0;
   logic [1:0] flt_mem_mode = '0;
   logic [2:0] flt_mem_idx = '0;
   logic [1:0] flt_mux_mode = '0;
   logic [2:0] dout, dout_nf;
   int checks = 0;
   int failures = 0;
   logic [N-1:0] cur_cfg = '0;

   always #2 clk = ~clk;

   lut_test_cell #(.K(K), .FAULT_EN(1'b1)) u_lut_test_cell (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .din(din),
      .alt_in(alt_in), .flt_mem_mode(flt_mem_mode), .flt_mem_idx(flt_mem_idx),
      .flt_mux_mode(flt_mux_mode), .dout(dout));

   lut_test_cell #(.K(K), .FAULT_EN(1'b0)) u_lut_test_cell_nf (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .din(din),
      .alt_in(alt_in), .flt_mem_mode(flt_mem_mode), .flt_mem_idx(flt_mem_idx),
      .flt_mux_mode(flt_mux_mode), .dout(dout_nf));

   function automatic logic [N-1:0] mk(logic [7:0] tbl, int p, bit rg, bit al);
      return {al, rg, 2'(p), tbl};
   endfunction

   function automatic logic [7:0] tc_table(int i, bit inv);
      logic [7:0] t;
      for (int a = 0; a < 8; a++) t[a] = ((a >> i) & 1) != 0;
      return inv ? ~t : t;
   endfunction

   function automatic logic [2:0] model(logic [N-1:0] w, logic [2:0] d, logic a,
                                        int mm, int idx, int xm, bit fen);
      logic [7:0] t;
      logic lb, m;
      logic [2:0] r;
      int p;
      t = w[7:0];
      p = int'(w[9:8]);
      lb = t[d];
      if (fen) begin
         if (mm == 1 && int'(d) == idx) lb = 1'b0;
         if (mm == 2 && int'(d) == idx) lb = 1'b1;
         if (mm == 3) lb = t[d] | t[idx];
      end
      m = w[11] ? a : lb;
      if (fen) begin
         if (xm == 1) m = 1'b0;
         if (xm == 2) m = 1'b1;
         if (xm == 3) m = lb | a;
      end
      r = d;
      if (p < K) r[p] = m;
      return r;
   endfunction

   task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic load(logic [N-1:0] w);
      for (int b = N - 1; b >= 0; b--) begin
         @(negedge clk);
         cfg_en  = 1'b1;
         cfg_bit = w[b];
      end
      @(negedge clk);
      cfg_en  = 1'b0;
      cur_cfg = w;
   endtask

   task automatic sweep_comb(string tag, int mm, int idx, int xm);
      for (int d = 0; d < 8; d++) begin
         for (int a = 0; a < 2; a++) begin
            @(negedge clk);
            din = 3'(d); alt_in = a[0];
            flt_mem_mode = 2'(mm); flt_mem_idx = 3'(idx); flt_mux_mode = 2'(xm);
            #1;
            chk(tag, dout, model(cur_cfg, din, alt_in, mm, idx, xm, 1'b1));
            chk({tag, " R11"}, dout_nf, model(cur_cfg, din, alt_in, mm, idx, xm, 1'b0));
         end
      end
      flt_mem_mode = '0; flt_mux_mode = '0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [2:0] prev;
      logic [N-1:0] wa, ws;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 / R8: registered identity-position-1 config, then reset pulse
      load(mk(tc_table(1, 1'b0), 1, 1'b1, 1'b0));
      din = 3'd5;
      @(posedge clk); #1;
      chk("R8 registered capture", dout, 3'd5);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      chk("R1 reset clears", dout, 3'd0);
      chk("R1 reset clears nf", dout_nf, 3'd0);
      @(posedge clk); #1;
      chk("R1 reset held", dout, 3'd0);
      @(negedge clk); rst = 1'b0;
      @(posedge clk); #1;
      chk("R1 release", dout, 3'd5);

      // R8: one cycle latency, no combinational path while registered
      @(negedge clk); din = 3'd0; @(posedge clk); #1; prev = 3'd0;
      for (int d = 1; d < 8; d++) begin
         @(negedge clk); din = 3'(d); #1;
         chk("R8 no early change", dout, prev);
         @(posedge clk); #1;
         chk("R8 one cycle latency", dout, 3'(d));
         prev = 3'(d);
      end

      // R6 / R4 / R3: identity and inverted test configurations
      for (int i = 0; i < K; i++) begin
         load(mk(tc_table(i, 1'b0), i, 1'b0, 1'b0));
         for (int d = 0; d < 8; d++) begin
            @(negedge clk); din = 3'(d); #1;
            chk("R6 identity", dout, 3'(d));
            chk("R6 identity nf", dout_nf, 3'(d));
         end
         load(mk(tc_table(i, 1'b1), i, 1'b0, 1'b0));
         for (int d = 0; d < 8; d++) begin
            @(negedge clk); din = 3'(d); #1;
            chk("R6 inverted", dout, 3'(d) ^ 3'(1 << i));
         end
      end

      // R4 / R3: arbitrary table
      load(mk(8'hB4, 1, 1'b0, 1'b0));
      sweep_comb("R4 arbitrary table", 0, 0, 0);

      // R5: out-of-range position
      load(mk(8'hFF, 3, 1'b0, 1'b0));
      for (int d = 0; d < 8; d++) begin
         @(negedge clk); din = 3'(d); #1;
         chk("R5 no placement", dout, 3'(d));
      end

      // R7: alternate input; two tables must give the same result
      load(mk(8'h00, 0, 1'b0, 1'b1));
      sweep_comb("R7 alt select", 0, 0, 0);
      load(mk(8'hFF, 2, 1'b0, 1'b1));
      sweep_comb("R7 alt select", 0, 0, 0);

      // R2: config holds while cfg_bit toggles with cfg_en low
      for (int c = 0; c < 6; c++) begin
         @(negedge clk); cfg_bit = ~cfg_bit;
      end
      sweep_comb("R2 hold", 0, 0, 0);

      // R9 / R10 / R11: faults on position-0 identity config
      load(mk(tc_table(0, 1'b0), 0, 1'b0, 1'b0));
      for (int mm = 1; mm < 4; mm++)
         for (int idx = 0; idx < 8; idx += 3)
            sweep_comb("R9 table fault", mm, idx, 0);
      load(mk(tc_table(0, 1'b1), 0, 1'b0, 1'b1));
      for (int xm = 1; xm < 4; xm++)
         sweep_comb("R10 mux fault", 0, 0, xm);

      // R12: reset and shift in the same cycle
      wa = mk(8'h5A, 1, 1'b1, 1'b0);
      load(wa);
      din = 3'd6;
      @(posedge clk);
      @(negedge clk); rst = 1'b1; cfg_en = 1'b1; cfg_bit = 1'b1;
      @(negedge clk); rst = 1'b0; cfg_en = 1'b0;
      ws = {wa[N-2:0], 1'b1};
      cur_cfg = ws;
      sweep_comb("R12 shift during reset", 0, 0, 0);

      finish_run();
   end
endmodule